// File: doc/BRIEF.md
# I2C Master Receive Command Sequencer

This block is the bus engine of an I2C controller that is fed through a queue of 11-bit command words. Software writes commands into a small command FIFO. The sequencer takes them one at a time and turns each into bus activity on SCL and SDA. It can issue a START with an address byte, send a data byte, issue a STOP, or clock in a counted run of bytes. Each received byte is placed in a receive FIFO as soon as its eighth bit is sampled. Software can therefore read a leading length byte while the rest of the run is still arriving.

The acknowledge bit sent after the final byte of a counted read is chosen while the transfer runs. Shortly before that acknowledge clock, the sequencer looks at the head of the command FIFO. If the head is another receive command, the sequencer takes it, acknowledges the byte and carries on reading with the new count. Two queued reads therefore become one unbroken acknowledged read. Otherwise the byte is answered with NACK.

The bit timing comes from a one-cycle `tick` enable. Each SCL period lasts two ticks: one with SCL low and one with SCL high. SCL is a push-pull level where 1 means released. SDA is open drain and is shown by `sda_low`.

Top module: `i2c_rx_cmd_seq`

## Requirements
- R1: A command word carries its operation in bits 10:8 and an 8-bit argument in bits 7:0. Operation 3'b001 is a receive, so word 0x100 reads exactly one byte.
- R2: A receive command with argument N clocks in N+1 bytes, MSB first. Each byte is pushed into the receive FIFO, in arrival order.
- R3: Every byte of a receive command except its last is acknowledged: `sda_low`=1 during the 9th SCL pulse.
- R4: The last byte of a receive command is acknowledged when the command FIFO head is another receive command (3'b001). That command is consumed and its bytes follow with no STOP or START in between. Any other head gives NACK (`sda_low`=0 on the 9th pulse).
- R5: An empty command FIFO at the decision point gives NACK. The decision point is the falling SCL edge after the 8th data pulse. A receive command pushed after that point cannot turn that NACK into an ACK; it starts a separate read afterwards.
- R6: When the receive FIFO is full, the sequencer holds SCL low before the first bit of the next byte until a byte is read out. No received byte is ever lost.
- R7: Operation 3'b100 makes a START: SDA falls while SCL is high. The argument is then sent as an address byte, MSB first, with `sda_low`=~bit, and SDA is released on the 9th pulse. Operation 3'b000 sends its argument the same way without the START.
- R8: Operation 3'b010 makes a STOP: SDA rises while SCL is high. The sequencer then goes idle with SCL released, SDA released and `busy`=0.
- R9: Any operation other than 3'b000, 3'b001, 3'b010 or 3'b100 is discarded without bus activity and sets the sticky `err_code`.
- R10: A command write while the command FIFO is full is dropped and sets the sticky `err_ovf`.
- R11: After reset: SCL released, SDA released, `busy`=0, `rx_empty`=1, both error flags 0.
- R12: During a byte transfer, `sda_low` only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Half-SCL-period enable |
| cmd_wr | input | 1 | Command FIFO write strobe |
| cmd_data | input | 11 | Command word: operation 10:8, argument 7:0 |
| sda_in | input | 1 | Sampled SDA line level |
| rx_rd | input | 1 | Receive FIFO read strobe |
| scl_out | output | 1 | SCL level, 1 = released |
| sda_low | output | 1 | 1 = pull SDA low |
| rx_data | output | 8 | Receive FIFO head byte |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| cmd_full | output | 1 | Command FIFO full |
| busy | output | 1 | Not idle |
| err_code | output | 1 | Sticky unknown-operation flag |
| err_ovf | output | 1 | Sticky command overflow flag |

## Verification
A scoreboard-driven target model answers with a known byte pattern. The patterns used are:
- a single one-byte read;
- a three-byte read, which shows counting and the plain ACK-then-NACK ending;
- two reads queued together, whose acknowledge pattern shows whether they merged;
- a second read pushed only after the acknowledge decision, which must give two separate NACKs.
A six-byte read with the receive FIFO left unread separates stalling from data loss. An address transfer, an unknown operation and a burst of writes into a full command FIFO check the START/STOP conditions and both sticky flags.

// File: rtl/i2c_rx_cmd_seq.sv
module i2c_rx_cmd_seq #(
  parameter int CMD_DEPTH = 4,
  parameter int RX_DEPTH  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        cmd_wr,
  input  logic [10:0] cmd_data,
  input  logic        sda_in,
  input  logic        rx_rd,
  output logic        scl_out,
  output logic        sda_low,
  output logic [7:0]  rx_data,
  output logic        rx_empty,
  output logic        rx_full,
  output logic        cmd_full,
  output logic        busy,
  output logic        err_code,
  output logic        err_ovf
);
  localparam int CAW = $clog2(CMD_DEPTH);
  localparam int RAW = $clog2(RX_DEPTH);
  localparam logic [2:0] OP_TX = 3'b000, OP_RX = 3'b001, OP_STOP = 3'b010, OP_START = 3'b100;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RS, S_START, S_BIT, S_STOP0, S_STOP1} st_t;

  // command FIFO
  logic [10:0]  cmem [CMD_DEPTH];
  logic [CAW:0] cwp, crp;
  logic         cmd_empty, cmd_pop;
  logic [10:0]  head;
  logic [2:0]   head_op;

  assign cmd_empty = (cwp == crp);
  assign cmd_full  = (cwp[CAW] != crp[CAW]) && (cwp[CAW-1:0] == crp[CAW-1:0]);
  assign head      = cmem[crp[CAW-1:0]];
  assign head_op   = head[10:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp <= '0;
      crp <= '0;
    end else begin
      if (cmd_wr && !cmd_full) begin
        cmem[cwp[CAW-1:0]] <= cmd_data;
        cwp <= cwp + 1'b1;
      end
      if (cmd_pop) crp <= crp + 1'b1;
    end
  end

  // receive FIFO
  logic [7:0]   rmem [RX_DEPTH];
  logic [RAW:0] rwp, rrp;
  logic         rx_push;
  logic [7:0]   rx_byte;

  assign rx_empty = (rwp == rrp);
  assign rx_full  = (rwp[RAW] != rrp[RAW]) && (rwp[RAW-1:0] == rrp[RAW-1:0]);
  assign rx_data  = rmem[rrp[RAW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rwp <= '0;
      rrp <= '0;
    end else begin
      if (rx_push && !rx_full) begin
        rmem[rwp[RAW-1:0]] <= rx_byte;
        rwp <= rwp + 1'b1;
      end
      if (rx_rd && !rx_empty) rrp <= rrp + 1'b1;
    end
  end

  // sequencer
  st_t        st;
  logic       phase, rxm, ack_r;
  logic [3:0] bitc;
  logic [7:0] cnt, shreg;
  logic       launch, decide, merge, adv;

  assign launch  = tick && !cmd_empty && (st == S_IDLE || st == S_WAIT);
  assign decide  = tick && st == S_BIT && rxm && phase && bitc == 4'd7 && cnt == 8'd0;
  assign merge   = decide && !cmd_empty && head_op == OP_RX;
  assign cmd_pop = launch || merge;
  assign adv     = !(st == S_BIT && rxm && bitc == 4'd0 && !phase && rx_full);
  assign rx_push = tick && st == S_BIT && rxm && phase && bitc == 4'd7;
  assign rx_byte = {shreg[6:0], sda_in};
  assign busy    = (st != S_IDLE);

  assign scl_out = (st == S_IDLE) || (st == S_RS) || (st == S_START) || (st == S_STOP1) ||
                   (st == S_BIT && phase);
  assign sda_low = (st == S_START) || (st == S_STOP0) || (st == S_STOP1) ||
                   (st == S_BIT && (rxm ? (bitc == 4'd8 && ack_r) : (bitc < 4'd8 && !shreg[7])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      phase    <= 1'b0;
      rxm      <= 1'b0;
      ack_r    <= 1'b0;
      bitc     <= '0;
      cnt      <= '0;
      shreg    <= '0;
      err_code <= 1'b0;
      err_ovf  <= 1'b0;
    end else begin
      if (cmd_wr && cmd_full) err_ovf <= 1'b1;
      if (tick) begin
        case (st)
          S_IDLE, S_WAIT: if (!cmd_empty) begin
            bitc  <= '0;
            phase <= 1'b0;
            case (head_op)
              OP_RX:    begin st <= S_BIT; rxm <= 1'b1; cnt <= head[7:0]; end
              OP_TX:    begin st <= S_BIT; rxm <= 1'b0; shreg <= head[7:0]; end
              OP_STOP:  st <= S_STOP0;
              OP_START: begin st <= (st == S_IDLE) ? S_START : S_RS; rxm <= 1'b0; shreg <= head[7:0]; end
              default:  err_code <= 1'b1;
            endcase
          end
          S_RS:    st <= S_START;
          S_START: begin st <= S_BIT; bitc <= '0; phase <= 1'b0; end
          S_BIT: if (adv) begin
            if (!phase) phase <= 1'b1;
            else begin
              phase <= 1'b0;
              if (bitc < 4'd8) begin
                bitc  <= bitc + 4'd1;
                shreg <= rxm ? rx_byte : {shreg[6:0], 1'b0};
                if (rxm && bitc == 4'd7) begin
                  ack_r <= (cnt != 8'd0) || merge;
                  if (cnt != 8'd0) cnt <= cnt - 8'd1;
                  else if (merge) cnt <= head[7:0];
                end
              end else begin
                bitc <= '0;
                if (!(rxm && ack_r)) st <= S_WAIT;
              end
            end
          end
          S_STOP0: st <= S_STOP1;
          S_STOP1: st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r12_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && phase && $past(st == S_BIT)) |-> $stable(sda_low));
  a_r6_stall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && rxm && bitc == 4'd0 && !phase && rx_full) |=> !scl_out);
  a_r6_no_lost_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  a_r9_code_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_code |=> err_code);
  a_r10_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_full) |=> err_ovf);
endmodule

// File: tb/test_i2c_rx_cmd_seq.sv
module test_i2c_rx_cmd_seq;
  logic clk = 0, rst_n = 0, tick = 0, cmd_wr = 0, rx_rd = 0;
  logic [10:0] cmd_data = '0;
  logic tgt_bit = 1;
  logic sda_in;
  logic scl_out, sda_low, rx_empty, rx_full, cmd_full, busy, err_code, err_ovf;
  logic [7:0] rx_data;

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  logic       ack_q[$];
  int  pulse = 0;
  bit  pop_en = 1, tx_cap_en = 0;
  int  start_seen = 0, stop_seen = 0;
  logic [7:0] tx_cap;
  logic prev_scl = 1, prev_sda = 0;

  always #5 clk = ~clk;
  assign sda_in = tgt_bit & ~sda_low;

  i2c_rx_cmd_seq i_i2c_rx_cmd_seq (.clk, .rst_n, .tick, .cmd_wr, .cmd_data, .sda_in, .rx_rd,
    .scl_out, .sda_low, .rx_data, .rx_empty, .rx_full, .cmd_full, .busy, .err_code, .err_ovf);

  function automatic logic [7:0] pat(int n);
    return 8'h5A ^ 8'(n * 29);
  endfunction
  function automatic logic tgt(int p);
    return (p % 9 == 8) ? 1'b1 : pat(p / 9)[7 - (p % 9)];
  endfunction

  task automatic chk(bit ok, string req, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % 4;
      tick = (c == 0);
    end
  end

  // monitor: bus edges, acknowledge scoreboard, receive FIFO scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_scl && scl_out && !prev_sda && sda_low) start_seen++;
      if (prev_scl && scl_out && prev_sda && !sda_low) stop_seen++;
      if (!prev_scl && scl_out) begin
        if (tx_cap_en && pulse < 8) tx_cap[7 - pulse] = ~sda_low;
        if (pulse % 9 == 8) begin
          if (ack_q.size() == 0) chk(0, "R4 unexpected acknowledge pulse", sda_low, 0);
          else begin
            logic e;
            e = ack_q.pop_front();
            chk(sda_low == e, "R3/R4/R5 acknowledge level", sda_low, e);
          end
        end
        pulse++;
      end
      if (prev_scl && !scl_out) tgt_bit = tgt(pulse);
      if (pop_en && !rx_empty) begin
        rx_rd = 1;
        if (exp_q.size() == 0) chk(0, "R2 unexpected byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R2 received byte", rx_data, e);
        end
      end else rx_rd = 0;
    end
    prev_scl = scl_out;
    prev_sda = sda_low;
  end

  task automatic push(logic [10:0] w);
    @(negedge clk);
    cmd_wr = 1; cmd_data = w;
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic new_test();
    pulse = 0;
    tgt_bit = tgt(0);
  endtask

  task automatic expect_read(int first, int n, bit last_ack);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(pat(first + i));
      ack_q.push_back((i < n - 1) ? 1'b1 : last_ack);
    end
  endtask

  task automatic finish_wait();
    repeat (40) @(negedge clk);
    while (!(exp_q.size() == 0 && ack_q.size() == 0 && !busy)) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    $display("FAIL watchdog expired");
    errors++; checks++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(scl_out == 1 && sda_low == 0, "R11 bus released", {scl_out, sda_low}, 2);
    chk(busy == 0 && rx_empty == 1, "R11 idle/empty", {busy, rx_empty}, 1);
    chk(err_code == 0 && err_ovf == 0, "R11 flags clear", {err_code, err_ovf}, 0);

    // R1: 0x100 reads one byte, then NACK
    new_test();
    expect_read(0, 1, 0);
    push(11'h100); push(11'h200);
    finish_wait();
    chk(scl_out == 1 && sda_low == 0, "R8 released after stop", {scl_out, sda_low}, 2);
    chk(stop_seen == 1, "R8 stop condition", stop_seen, 1);

    // R2/R3: three-byte read
    new_test();
    expect_read(0, 3, 0);
    push(11'h102); push(11'h200);
    finish_wait();

    // R4: queued reads merge
    new_test();
    expect_read(0, 2, 1);
    expect_read(2, 1, 0);
    push(11'h101); push(11'h100); push(11'h200);
    finish_wait();
    chk(stop_seen == 3 && start_seen == 0, "R4 no stop/start inside merged read", stop_seen, 3);

    // R5: late push after decision point
    new_test();
    expect_read(0, 1, 0);
    expect_read(1, 1, 0);
    push(11'h100);
    while (pulse < 9) @(negedge clk);
    push(11'h100); push(11'h200);
    finish_wait();

    // R6: stall on full receive FIFO
    new_test();
    pop_en = 0;
    expect_read(0, 6, 0);
    push(11'h105); push(11'h200);
    while (!rx_full) @(negedge clk);
    repeat (200) @(negedge clk);
    chk(scl_out == 0, "R6 SCL held low while full", scl_out, 0);
    chk(pulse == 36, "R6 no clocks while full", pulse, 36);
    pop_en = 1;
    finish_wait();

    // R7: START + address, then a one-byte read
    new_test();
    start_seen = 0;
    tx_cap_en = 1;
    ack_q.push_back(1'b0);
    expect_read(1, 1, 0);
    push(11'h4A6); push(11'h100); push(11'h200);
    finish_wait();
    tx_cap_en = 0;
    chk(start_seen == 1, "R7 start condition", start_seen, 1);
    chk(tx_cap == 8'hA6, "R7 address bits", tx_cap, 8'hA6);

    // R9: unknown operation
    new_test();
    push(11'h355);
    repeat (40) @(negedge clk);
    chk(err_code == 1, "R9 sticky code error", err_code, 1);
    chk(busy == 0 && scl_out == 1 && pulse == 0, "R9 no bus activity", pulse, 0);

    // R10: command FIFO overflow
    new_test();
    chk(err_ovf == 0, "R10 flag clear before burst", err_ovf, 0);
    @(negedge clk);
    cmd_wr = 1; cmd_data = 11'h200;
    repeat (6) @(negedge clk);
    cmd_wr = 0;
    chk(err_ovf == 1, "R10 sticky overflow", err_ovf, 1);
    finish_wait();
    chk(err_ovf == 1 && err_code == 1, "R10 flags stay set", {err_code, err_ovf}, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule